// File: doc/BRIEF.md
# I2C Multi-Payload Command Sequencer

This block drives an I2C bit engine through one command made of an ordered list of payloads. Each payload names a 7-bit target, a direction and a byte count. The payloads of one command are chained with repeated STARTs, so that the bus is released only after the final payload. For each payload the sequencer asks the engine for a START and then for the address byte. It then moves the data bytes. Written bytes come from a byte stream, and read bytes are sent out on a valid-only stream.

When a command is accepted, the sequencer turns the requested bus speed into the clock-delay value that the engine uses. It does this with an iterative divider, before any bus activity. A failed bus step ends the current payload with a forced STOP, and the rest of the command is dropped. A single-cycle `done` pulse then reports the result on `success`.

The engine interface works one operation at a time. `eng_req` pulses for one cycle with `eng_op`, which is 0 for START, 1 for STOP, 2 for a byte write and 3 for a byte read. The engine answers later with a one-cycle `eng_done` and `eng_ok`. For a write, `eng_ok` is high when the target returned ACK.

Top module: `i2c_cmd_sequencer`

## Requirements
- R1: The address byte is issued as a write operation (eng_op=2) with eng_wdata equal to the 7-bit address in bits 7..1 and the direction in bit 0 (1 for read, 0 for write).
- R2: Every payload except the final one ends without a STOP, and the next payload opens with a START (eng_op=0).
- R3: After the final payload of a command succeeds, a STOP (eng_op=1) is issued and `done` pulses with `success`=1.
- R4: A failed START, or a NACK on the address or on any written byte, forces a STOP at once. No further descriptor is accepted, and `done` pulses with `success`=0.
- R5: A STOP that the engine reports as failed makes the command end with `success`=0.
- R6: In a read payload, every byte except the last is requested with eng_rd_ack=1 (ACK) and the last with eng_rd_ack=0 (NACK). Each byte received appears once, in order, on rd_valid/rd_data.
- R7: Written data bytes are taken one at a time from the wr_valid/wr_ready stream and issued in stream order.
- R8: clk_delay becomes 1000 divided by cmd_speed (integer quotient), raised to 12 if smaller. A cmd_speed of 0 uses a speed of 50, which gives 20.
- R9: clk_delay holds its new value before the first START of the command is requested, and does not change while operations are requested.
- R10: A payload of length zero issues only START and the address byte, then follows the usual STOP rule.
- R11: After reset, done, eng_req, desc_ready and wr_ready are low and clk_delay is 20.
- R12: done is a single-cycle pulse per command, and only one descriptor or write byte is taken per handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | Start a command (ignored while busy) |
| cmd_speed | input | SPD_W | Requested bus speed, 0 selects the default |
| cmd_count | input | CNT_W | Number of payloads in the command |
| desc_valid | input | 1 | Payload descriptor valid |
| desc_ready | output | 1 | Descriptor accepted this cycle when valid |
| desc_addr | input | 7 | Target address |
| desc_read | input | 1 | 1 = read payload, 0 = write payload |
| desc_len | input | LEN_W | Number of data bytes |
| wr_valid | input | 1 | Write byte valid |
| wr_ready | output | 1 | Write byte taken when valid |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte strobe |
| rd_data | output | 8 | Read byte |
| eng_req | output | 1 | One-cycle operation request to the engine |
| eng_op | output | 2 | 0 START, 1 STOP, 2 write byte, 3 read byte |
| eng_wdata | output | 8 | Byte to write |
| eng_rd_ack | output | 1 | For reads: 1 send ACK, 0 send NACK |
| eng_done | input | 1 | Engine finished the operation |
| eng_ok | input | 1 | Operation succeeded (ACK on writes) |
| eng_rdata | input | 8 | Byte read by the engine |
| clk_delay | output | DLY_W | Engine clock-delay setting |
| done | output | 1 | Command finished pulse |
| success | output | 1 | Command result, valid with done |

## Verification
The bench runs single write and read payloads, a write followed by a read chained with a repeated START, and a zero-length payload ahead of a write. These cases separate correct STOP placement from a STOP after every payload, and they show the ACK/NACK choice on the last read byte. Faults are injected at four points: at START, on the address, on a middle data byte and at STOP. Each fault shows whether the abort takes a forced STOP, leaves the later descriptors unconsumed and reports failure. Speeds of 0, 7, 40 and 100 cover the default path, a large quotient, an exact quotient and the floor clamp.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_STOP  = 2'd1,
    OP_WRITE = 2'd2,
    OP_READ  = 2'd3
  } eng_op_t;

  typedef enum logic [3:0] {
    S_IDLE,
    S_DIV,
    S_DESC,
    S_START,
    S_WSTART,
    S_ADDR,
    S_WADDR,
    S_WRGET,
    S_BYTE,
    S_WBYTE,
    S_STOP,
    S_WSTOP,
    S_FIN
  } seq_state_t;

endpackage

// File: rtl/i2c_seq_divider.sv
module i2c_seq_divider #(
  parameter int SPD_W     = 16,
  parameter int NUMER     = 1000,
  parameter int FLOOR     = 12,
  parameter int DEF_SPEED = 50,
  parameter int DLY_W     = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [SPD_W-1:0] speed,
  output logic             fin,
  output logic [DLY_W-1:0] delay
);

  localparam int REM_W   = SPD_W + 1;
  localparam int CNT_W   = $clog2(DLY_W + 1);
  localparam int DEF_Q   = NUMER / DEF_SPEED;
  localparam int DEF_DLY = (DEF_Q < FLOOR) ? FLOOR : DEF_Q;

  logic [DLY_W-1:0] num_q, quo_q, quo_next;
  logic [SPD_W-1:0] den_q;
  logic [REM_W-1:0] rem_q, shifted, diff;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q, ge;

  always_comb begin
    shifted  = {rem_q[SPD_W-1:0], num_q[DLY_W-1]};
    ge       = shifted >= {1'b0, den_q};
    diff     = shifted - {1'b0, den_q};
    quo_next = {quo_q[DLY_W-2:0], ge};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      fin   <= 1'b0;
      delay <= DLY_W'(DEF_DLY);
      num_q <= '0;
      quo_q <= '0;
      den_q <= '0;
      rem_q <= '0;
      cnt_q <= '0;
    end else begin
      fin <= 1'b0;
      if (start && !run_q) begin
        run_q <= 1'b1;
        num_q <= DLY_W'(NUMER);
        den_q <= (speed == '0) ? SPD_W'(DEF_SPEED) : speed;
        rem_q <= '0;
        quo_q <= '0;
        cnt_q <= CNT_W'(DLY_W);
      end else if (run_q) begin
        rem_q <= ge ? diff : shifted;
        quo_q <= quo_next;
        num_q <= num_q << 1;
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          run_q <= 1'b0;
          fin   <= 1'b1;
          delay <= (quo_next < DLY_W'(FLOOR)) ? DLY_W'(FLOOR) : quo_next;
        end
      end
    end
  end

endmodule

// File: rtl/i2c_seq_ctrl.sv
module i2c_seq_ctrl
  import i2c_seq_pkg::*;
#(
  parameter int SPD_W = 16,
  parameter int CNT_W = 4,
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_start,
  input  logic [SPD_W-1:0] cmd_speed,
  input  logic [CNT_W-1:0] cmd_count,
  output logic             div_start,
  output logic [SPD_W-1:0] div_speed,
  input  logic             div_fin,
  input  logic             desc_valid,
  output logic             desc_ready,
  input  logic [6:0]       desc_addr,
  input  logic             desc_read,
  input  logic [LEN_W-1:0] desc_len,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [7:0]       wr_data,
  output logic             rd_valid,
  output logic [7:0]       rd_data,
  output logic             eng_req,
  output logic [1:0]       eng_op,
  output logic [7:0]       eng_wdata,
  output logic             eng_rd_ack,
  input  logic             eng_done,
  input  logic             eng_ok,
  input  logic [7:0]       eng_rdata,
  output logic             done,
  output logic             success
);

  seq_state_t       state;
  logic [CNT_W-1:0] remain_q;
  logic [LEN_W-1:0] left_q;
  logic [6:0]       addr_q;
  logic [7:0]       byte_q;
  logic             rd_q, last_q, fail_q;

  assign desc_ready = (state == S_DESC);
  assign wr_ready   = (state == S_WRGET);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      remain_q   <= '0;
      left_q     <= '0;
      addr_q     <= '0;
      byte_q     <= '0;
      rd_q       <= 1'b0;
      last_q     <= 1'b0;
      fail_q     <= 1'b0;
      div_start  <= 1'b0;
      div_speed  <= '0;
      rd_valid   <= 1'b0;
      rd_data    <= '0;
      eng_req    <= 1'b0;
      eng_op     <= OP_START;
      eng_wdata  <= '0;
      eng_rd_ack <= 1'b0;
      done       <= 1'b0;
      success    <= 1'b0;
    end else begin
      div_start <= 1'b0;
      rd_valid  <= 1'b0;
      eng_req   <= 1'b0;
      done      <= 1'b0;
      case (state)
        S_IDLE: begin
          if (cmd_start) begin
            remain_q  <= cmd_count;
            div_speed <= cmd_speed;
            fail_q    <= 1'b0;
            div_start <= 1'b1;
            state     <= S_DIV;
          end
        end
        S_DIV: begin
          if (div_fin) state <= (remain_q == '0) ? S_FIN : S_DESC;
        end
        S_DESC: begin
          if (desc_valid) begin
            addr_q   <= desc_addr;
            rd_q     <= desc_read;
            left_q   <= desc_len;
            last_q   <= (remain_q == CNT_W'(1));
            remain_q <= remain_q - 1'b1;
            state    <= S_START;
          end
        end
        S_START: begin
          eng_req <= 1'b1;
          eng_op  <= OP_START;
          state   <= S_WSTART;
        end
        S_WSTART: begin
          if (eng_done) begin
            if (eng_ok) state <= S_ADDR;
            else begin
              fail_q <= 1'b1;
              state  <= S_STOP;
            end
          end
        end
        S_ADDR: begin
          eng_req   <= 1'b1;
          eng_op    <= OP_WRITE;
          eng_wdata <= {addr_q, rd_q};
          state     <= S_WADDR;
        end
        S_WADDR: begin
          if (eng_done) begin
            if (!eng_ok) begin
              fail_q <= 1'b1;
              state  <= S_STOP;
            end else if (left_q == '0) begin
              state <= last_q ? S_STOP : S_DESC;
            end else begin
              state <= rd_q ? S_BYTE : S_WRGET;
            end
          end
        end
        S_WRGET: begin
          if (wr_valid) begin
            byte_q <= wr_data;
            state  <= S_BYTE;
          end
        end
        S_BYTE: begin
          eng_req    <= 1'b1;
          eng_op     <= rd_q ? OP_READ : OP_WRITE;
          eng_wdata  <= byte_q;
          eng_rd_ack <= (left_q != LEN_W'(1));
          state      <= S_WBYTE;
        end
        S_WBYTE: begin
          if (eng_done) begin
            if (!eng_ok) begin
              fail_q <= 1'b1;
              state  <= S_STOP;
            end else begin
              if (rd_q) begin
                rd_valid <= 1'b1;
                rd_data  <= eng_rdata;
              end
              left_q <= left_q - 1'b1;
              if (left_q == LEN_W'(1)) state <= last_q ? S_STOP : S_DESC;
              else state <= rd_q ? S_BYTE : S_WRGET;
            end
          end
        end
        S_STOP: begin
          eng_req <= 1'b1;
          eng_op  <= OP_STOP;
          state   <= S_WSTOP;
        end
        S_WSTOP: begin
          if (eng_done) begin
            if (!eng_ok) fail_q <= 1'b1;
            state <= S_FIN;
          end
        end
        S_FIN: begin
          done    <= 1'b1;
          success <= !fail_q;
          state   <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/i2c_cmd_sequencer.sv
module i2c_cmd_sequencer #(
  parameter int SPD_W     = 16,
  parameter int CNT_W     = 4,
  parameter int LEN_W     = 8,
  parameter int NUMER     = 1000,
  parameter int FLOOR     = 12,
  parameter int DEF_SPEED = 50,
  parameter int DLY_W     = $clog2(NUMER + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_start,
  input  logic [SPD_W-1:0] cmd_speed,
  input  logic [CNT_W-1:0] cmd_count,
  input  logic             desc_valid,
  output logic             desc_ready,
  input  logic [6:0]       desc_addr,
  input  logic             desc_read,
  input  logic [LEN_W-1:0] desc_len,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [7:0]       wr_data,
  output logic             rd_valid,
  output logic [7:0]       rd_data,
  output logic             eng_req,
  output logic [1:0]       eng_op,
  output logic [7:0]       eng_wdata,
  output logic             eng_rd_ack,
  input  logic             eng_done,
  input  logic             eng_ok,
  input  logic [7:0]       eng_rdata,
  output logic [DLY_W-1:0] clk_delay,
  output logic             done,
  output logic             success
);

  logic             div_start, div_fin;
  logic [SPD_W-1:0] div_speed;

  i2c_seq_divider #(
    .SPD_W(SPD_W), .NUMER(NUMER), .FLOOR(FLOOR),
    .DEF_SPEED(DEF_SPEED), .DLY_W(DLY_W)
  ) div_i (
    .clk(clk), .rst(rst), .start(div_start), .speed(div_speed),
    .fin(div_fin), .delay(clk_delay)
  );

  i2c_seq_ctrl #(
    .SPD_W(SPD_W), .CNT_W(CNT_W), .LEN_W(LEN_W)
  ) ctrl_i (
    .clk(clk), .rst(rst),
    .cmd_start(cmd_start), .cmd_speed(cmd_speed), .cmd_count(cmd_count),
    .div_start(div_start), .div_speed(div_speed), .div_fin(div_fin),
    .desc_valid(desc_valid), .desc_ready(desc_ready), .desc_addr(desc_addr),
    .desc_read(desc_read), .desc_len(desc_len),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .eng_req(eng_req), .eng_op(eng_op), .eng_wdata(eng_wdata),
    .eng_rd_ack(eng_rd_ack), .eng_done(eng_done), .eng_ok(eng_ok),
    .eng_rdata(eng_rdata), .done(done), .success(success)
  );

endmodule

// File: rtl/i2c_cmd_sequencer_chk.sv
module i2c_cmd_sequencer_chk #(
  parameter int DLY_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             desc_valid,
  input logic             desc_ready,
  input logic             wr_valid,
  input logic             wr_ready,
  input logic             rd_valid,
  input logic             eng_req,
  input logic [1:0]       eng_op,
  input logic             eng_done,
  input logic [DLY_W-1:0] clk_delay,
  input logic             done
);

  logic [1:0] last_op;
  logic       seen_op;

  always_ff @(posedge clk) begin
    if (rst) begin
      last_op <= 2'd0;
      seen_op <= 1'b0;
    end else if (eng_req) begin
      last_op <= eng_op;
      seen_op <= 1'b1;
    end else if (done) begin
      seen_op <= 1'b0;
    end
  end

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);

  // R3
  end_with_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (done && seen_op) |-> (last_op == 2'd1));

  // R9
  delay_steady_chk: assert property (@(posedge clk) disable iff (rst)
    eng_req |-> $stable(clk_delay));

  // R6
  rd_after_engine_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(eng_done));

  // R12
  one_desc_chk: assert property (@(posedge clk) disable iff (rst)
    (desc_valid && desc_ready) |=> !desc_ready);

  // R7
  one_wbyte_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_ready) |=> !wr_ready);

  // R12
  req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    eng_req |=> !eng_req);

endmodule

bind i2c_cmd_sequencer i2c_cmd_sequencer_chk #(.DLY_W(DLY_W)) chk_i (
  .clk(clk), .rst(rst), .desc_valid(desc_valid), .desc_ready(desc_ready),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .rd_valid(rd_valid),
  .eng_req(eng_req), .eng_op(eng_op), .eng_done(eng_done),
  .clk_delay(clk_delay), .done(done)
);

// File: tb/i2c_cmd_sequencer_tb_top.sv
`timescale 1ns/1ps
module i2c_cmd_sequencer_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_start = 1'b0;
  logic [15:0] cmd_speed = '0;
  logic [3:0]  cmd_count = '0;
  logic        desc_valid, desc_ready, desc_read;
  logic [6:0]  desc_addr;
  logic [7:0]  desc_len;
  logic        wr_valid, wr_ready;
  logic [7:0]  wr_data;
  logic        rd_valid;
  logic [7:0]  rd_data;
  logic        eng_req, eng_rd_ack;
  logic [1:0]  eng_op;
  logic [7:0]  eng_wdata;
  logic        eng_done, eng_ok;
  logic [7:0]  eng_rdata;
  logic [9:0]  clk_delay;
  logic        done, success;

  always #2 clk = ~clk;

  i2c_cmd_sequencer dut_i (.*);

  // bench-side configuration and logs
  logic        clr = 1'b0;
  logic [3:0]  n_desc = '0;
  logic [3:0]  nack_idx = 4'hF;
  logic        fail_start = 1'b0, fail_stop = 1'b0;
  logic [6:0]  d_addr [0:7];
  logic        d_read [0:7];
  logic [7:0]  d_len  [0:7];
  logic [7:0]  w_arr  [0:7];
  logic [3:0]  didx, widx, wcnt, rcnt, nlog, nrd, ndone;
  logic [1:0]  log_op [0:15];
  logic [7:0]  log_d  [0:15];
  logic [9:0]  log_dly [0:15];
  logic [7:0]  rd_log [0:15];
  logic [1:0]  pend_op;
  logic [2:0]  lat;
  logic        got_succ;

  assign desc_valid = (didx < n_desc);
  assign desc_addr  = d_addr[didx[2:0]];
  assign desc_read  = d_read[didx[2:0]];
  assign desc_len   = d_len[didx[2:0]];
  assign wr_valid   = 1'b1;
  assign wr_data    = w_arr[widx[2:0]];

  always @(posedge clk) begin
    eng_done <= 1'b0;
    if (clr) begin
      didx <= '0; widx <= '0; wcnt <= '0; rcnt <= '0;
      nlog <= '0; nrd <= '0; lat <= '0; ndone <= '0;
      eng_ok <= 1'b0; eng_rdata <= '0; got_succ <= 1'b0; pend_op <= '0;
    end else begin
      if (desc_valid && desc_ready) didx <= didx + 1'b1;
      if (wr_valid && wr_ready) widx <= widx + 1'b1;
      if (rd_valid) begin
        rd_log[nrd] <= rd_data;
        nrd <= nrd + 1'b1;
      end
      if (done) begin
        ndone <= ndone + 1'b1;
        got_succ <= success;
      end
      if (eng_req) begin
        log_op[nlog]  <= eng_op;
        log_d[nlog]   <= (eng_op == 2'd3) ? {7'd0, eng_rd_ack} :
                         (eng_op == 2'd2) ? eng_wdata : 8'd0;
        log_dly[nlog] <= clk_delay;
        nlog <= nlog + 1'b1;
        pend_op <= eng_op;
        lat <= 3'd3;
      end else if (lat != 3'd0) begin
        lat <= lat - 1'b1;
        if (lat == 3'd1) begin
          eng_done <= 1'b1;
          case (pend_op)
            2'd0: eng_ok <= !fail_start;
            2'd1: eng_ok <= !fail_stop;
            2'd2: begin eng_ok <= (wcnt != nack_idx); wcnt <= wcnt + 1'b1; end
            default: begin
              eng_ok <= 1'b1;
              eng_rdata <= 8'hA0 + {4'd0, rcnt};
              rcnt <= rcnt + 1'b1;
            end
          endcase
        end
      end
    end
  end

  int total = 0;
  int bad = 0;
  bit finished = 0;

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic prep(input logic [3:0] nd);
    @(negedge clk);
    clr = 1'b1;
    n_desc = nd;
    nack_idx = 4'hF;
    fail_start = 1'b0;
    fail_stop = 1'b0;
    @(negedge clk);
    clr = 1'b0;
  endtask

  task automatic set_desc(input logic [2:0] i, input logic [6:0] a,
                          input logic r, input logic [7:0] l);
    d_addr[i] = a; d_read[i] = r; d_len[i] = l;
  endtask

  task automatic run_cmd(input logic [3:0] cnt, input logic [15:0] spd);
    cmd_count = cnt;
    cmd_speed = spd;
    cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
    while (ndone == 4'd0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic exp_op(input string req, input logic [3:0] i,
                        input int op, input int d);
    check(req, int'(log_op[i]), op);
    check(req, int'(log_d[i]), d);
  endtask

  task automatic t_reset;
    check("R11 done", int'(done), 0);
    check("R11 eng_req", int'(eng_req), 0);
    check("R11 desc_ready", int'(desc_ready), 0);
    check("R11 wr_ready", int'(wr_ready), 0);
    check("R11 clk_delay", int'(clk_delay), 20);
  endtask

  task automatic t_single_write;
    prep(4'd1);
    set_desc(3'd0, 7'h50, 1'b0, 8'd2);
    w_arr[0] = 8'h11; w_arr[1] = 8'h22;
    run_cmd(4'd1, 16'd100);
    check("R3 ops", int'(nlog), 5);
    exp_op("R1 start", 4'd0, 0, 0);
    exp_op("R1 addr", 4'd1, 2, 8'hA0);
    exp_op("R7 byte0", 4'd2, 2, 8'h11);
    exp_op("R7 byte1", 4'd3, 2, 8'h22);
    exp_op("R3 stop", 4'd4, 1, 0);
    check("R3 success", int'(got_succ), 1);
    check("R12 one done", int'(ndone), 1);
    check("R8 floor", int'(clk_delay), 12);
    check("R9 delay at start", int'(log_dly[0]), 12);
  endtask

  task automatic t_single_read;
    prep(4'd1);
    set_desc(3'd0, 7'h50, 1'b1, 8'd3);
    run_cmd(4'd1, 16'd40);
    check("R6 ops", int'(nlog), 6);
    exp_op("R1 addr rd", 4'd1, 2, 8'hA1);
    exp_op("R6 ack0", 4'd2, 3, 1);
    exp_op("R6 ack1", 4'd3, 3, 1);
    exp_op("R6 nack last", 4'd4, 3, 0);
    exp_op("R3 stop", 4'd5, 1, 0);
    check("R6 rd count", int'(nrd), 3);
    check("R6 rd0", int'(rd_log[0]), 8'hA0);
    check("R6 rd2", int'(rd_log[2]), 8'hA2);
    check("R8 exact", int'(clk_delay), 25);
    check("R9 delay at start", int'(log_dly[0]), 25);
  endtask

  task automatic t_chain;
    prep(4'd2);
    set_desc(3'd0, 7'h3C, 1'b0, 8'd1);
    set_desc(3'd1, 7'h3C, 1'b1, 8'd2);
    w_arr[0] = 8'h05;
    run_cmd(4'd2, 16'd0);
    check("R2 ops", int'(nlog), 8);
    exp_op("R2 wr addr", 4'd1, 2, 8'h78);
    exp_op("R7 data", 4'd2, 2, 8'h05);
    exp_op("R2 restart", 4'd3, 0, 0);
    exp_op("R2 rd addr", 4'd4, 2, 8'h79);
    exp_op("R6 ack", 4'd5, 3, 1);
    exp_op("R6 nack", 4'd6, 3, 0);
    exp_op("R3 stop", 4'd7, 1, 0);
    check("R3 success", int'(got_succ), 1);
    check("R8 default", int'(clk_delay), 20);
  endtask

  task automatic t_addr_nack;
    prep(4'd2);
    set_desc(3'd0, 7'h10, 1'b0, 8'd1);
    set_desc(3'd1, 7'h11, 1'b0, 8'd1);
    nack_idx = 4'd0;
    run_cmd(4'd2, 16'd7);
    check("R4 ops", int'(nlog), 3);
    exp_op("R4 stop", 4'd2, 1, 0);
    check("R4 desc taken", int'(didx), 1);
    check("R4 success", int'(got_succ), 0);
    check("R8 large", int'(clk_delay), 142);
  endtask

  task automatic t_data_nack;
    prep(4'd3);
    set_desc(3'd0, 7'h20, 1'b0, 8'd2);
    set_desc(3'd1, 7'h21, 1'b0, 8'd1);
    set_desc(3'd2, 7'h22, 1'b0, 8'd1);
    w_arr[0] = 8'hC1; w_arr[1] = 8'hC2;
    nack_idx = 4'd2;
    run_cmd(4'd3, 16'd3);
    check("R4 ops", int'(nlog), 5);
    exp_op("R4 stop", 4'd4, 1, 0);
    check("R4 desc taken", int'(didx), 1);
    check("R4 wr taken", int'(widx), 2);
    check("R4 success", int'(got_succ), 0);
    check("R8 333", int'(clk_delay), 333);
  endtask

  task automatic t_start_fail;
    prep(4'd2);
    set_desc(3'd0, 7'h20, 1'b1, 8'd2);
    set_desc(3'd1, 7'h21, 1'b1, 8'd2);
    fail_start = 1'b1;
    run_cmd(4'd2, 16'd100);
    check("R4 ops", int'(nlog), 2);
    exp_op("R4 forced stop", 4'd1, 1, 0);
    check("R4 no rd", int'(nrd), 0);
    check("R4 success", int'(got_succ), 0);
  endtask

  task automatic t_stop_fail_zero;
    prep(4'd1);
    set_desc(3'd0, 7'h7F, 1'b0, 8'd0);
    fail_stop = 1'b1;
    run_cmd(4'd1, 16'd100);
    check("R10 ops", int'(nlog), 3);
    exp_op("R10 addr", 4'd1, 2, 8'hFE);
    exp_op("R10 stop", 4'd2, 1, 0);
    check("R5 success", int'(got_succ), 0);
  endtask

  task automatic t_zero_then_write;
    prep(4'd2);
    set_desc(3'd0, 7'h01, 1'b0, 8'd0);
    set_desc(3'd1, 7'h02, 1'b0, 8'd1);
    w_arr[0] = 8'h5A;
    run_cmd(4'd2, 16'd1000);
    check("R10 ops", int'(nlog), 6);
    exp_op("R10 addr", 4'd1, 2, 8'h02);
    exp_op("R10 restart", 4'd2, 0, 0);
    exp_op("R10 addr2", 4'd3, 2, 8'h04);
    exp_op("R7 data", 4'd4, 2, 8'h5A);
    exp_op("R3 stop", 4'd5, 1, 0);
    check("R3 success", int'(got_succ), 1);
    check("R8 floor", int'(clk_delay), 12);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) begin
      d_addr[i] = '0; d_read[i] = 1'b0; d_len[i] = '0; w_arr[i] = '0;
    end
    clr = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    clr = 1'b0;
    @(negedge clk);
    t_reset;
    t_single_write;
    t_single_read;
    t_chain;
    t_addr_nack;
    t_data_nack;
    t_start_fail;
    t_stop_fail_zero;
    t_zero_then_write;
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule